// File: doc/BRIEF.md
# Periodic Countdown Timer with Interrupt Output

This block is the timing core of a real-time-clock style device. It holds an 8-bit binary down-counter, a reload value, a sticky expiry flag and a control byte. All of these sit behind a small synchronous register bus. The count advances on tick enables that arrive from an outside prescaler. Software chooses one of four rates, indexed from fastest to slowest (nominally 4096 Hz, 64 Hz, 1 Hz and one tick per minute). Each time the count runs out, the flag is raised, and it stays up until software clears it.

The active-low interrupt output runs in one of two modes. In level mode it follows the flag. In pulse mode it gives one short low pulse per countdown period. Those pulses carry on after the flag is cleared and stop only when counting, the interrupt enable or the mode bit is switched off. A request from outside (alarm, watchdog timeout, oscillator failure, output-control bit) is merged in and always wins, so the output stays low whatever the timer is doing.

Register addresses: flags at 0x0F, current count at 0x10, control at 0x11. Reads are combinational on `bus_addr`.

Top module: `cdt_timer`

## Requirements
- R1: After reset, the three registers read 0x00 and `irq_n` is 1 while `ext_irq` is 0.
- R2: Writing address 0x10 sets both the reload value and the live count to the written byte. Reading 0x10 returns the live count.
- R3: The control fields are: bit 7 enable, bit 6 mode (1 = pulse), bit 5 interrupt enable, bits 1:0 rate select. While enable is 1, each clock with `tick_en[select]` high moves the count. A tick on an unselected rate does not move it, and neither does any tick while enable is 0.
- R4: A selected tick at count 1 takes the count to 0 and sets the flag (0x0F bit 3). A selected tick at count 0 reloads the last written value. With a reload value of 0 the count stays 0 and the flag is never set. A value write in the same cycle as a tick wins and causes no expiry.
- R5: The flag is cleared only by a write to 0x0F with bit 3 = 0; a write with bit 3 = 1 leaves it unchanged. If an expiry and a clearing write fall in the same cycle, the flag ends up set.
- R6: In level mode, `irq_n` is 0 exactly while the flag and the interrupt enable are both 1 (with `ext_irq` 0).
- R7: In pulse mode, with enable and interrupt enable set, `irq_n` goes low in the cycle after an expiry. It stays low until the next selected tick or for PULSE_CAP clocks, whichever comes first. Clearing the flag does not end the pulse.
- R8: Once enable, interrupt enable or mode reads 0, no timer pulse is visible on `irq_n`.
- R9: `ext_irq` = 1 forces `irq_n` to 0 in every mode.
- R10: Control bits 4:2 read as 0. Flag bits other than bit 3 read as 0. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| tick_en | input | 4 | Prescaled tick enables, index = rate select |
| ext_irq | input | 1 | Merged request from other interrupt sources, active high |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
Two collisions matter here, and each one is forced by a directed cycle. In the first, a counter expiry coincides with a software write that clears the flag: the tick that takes the count from 1 to 0 is issued together with a flags write of bit 3 = 0, and the flag must read as set afterwards. In the second, a pulse is running when the flag is cleared: the output must stay low and the pulse must end only at the next selected tick or at the width cap. Random traffic then overlaps ticks, value writes, control writes and external requests. Each cycle is judged against a reference model in the bench that is built from the requirements.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   // control register field positions
   localparam int CTRL_EN_BIT   = 7;
   localparam int CTRL_MODE_BIT = 6;
   localparam int CTRL_IE_BIT   = 5;
   localparam int CTRL_RSV_LO   = 2;
   localparam int CTRL_RSV_HI   = 4;
   // flag register field position
   localparam int FLAG_TF_BIT   = 3;

   typedef enum logic {
      IRQ_LEVEL = 1'b0,
      IRQ_PULSE = 1'b1
   } irq_mode_e;
endpackage

// File: rtl/cdt_ctrl_regs.sv
module cdt_ctrl_regs
   import cdt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8,
   parameter int SEL_W  = 2,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h0F,
   parameter logic [ADDR_W-1:0] VAL_ADDR  = 8'h10,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              expire,
   input  logic [CNT_W-1:0]  cnt,
   output logic              te,
   output logic              ie,
   output irq_mode_e         mode,
   output logic [SEL_W-1:0]  sel,
   output logic              tf,
   output logic              val_wr,
   output logic [DATA_W-1:0] rdata
);
   logic              flag_wr;
   logic              ctrl_wr;
   logic              te_q;
   logic              ie_q;
   irq_mode_e         mode_q;
   logic [SEL_W-1:0]  sel_q;
   logic              tf_q;
   logic              unused_wbits;

   assign flag_wr = we && (addr == FLAG_ADDR);
   assign ctrl_wr = we && (addr == CTRL_ADDR);
   assign val_wr  = we && (addr == VAL_ADDR);
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         te_q   <= 1'b0;
         ie_q   <= 1'b0;
         mode_q <= IRQ_LEVEL;
         sel_q  <= '0;
      end else if (ctrl_wr) begin
         te_q   <= wdata[CTRL_EN_BIT];
         ie_q   <= wdata[CTRL_IE_BIT];
         mode_q <= irq_mode_e'(wdata[CTRL_MODE_BIT]);
         sel_q  <= wdata[SEL_W-1:0];
      end
   end

   // sticky flag: hardware only sets, software only clears; set wins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tf_q <= 1'b0;
      end else if (expire) begin
         tf_q <= 1'b1;
      end else if (flag_wr && !wdata[FLAG_TF_BIT]) begin
         tf_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == FLAG_ADDR) begin
         rdata[FLAG_TF_BIT] = tf_q;
      end else if (addr == VAL_ADDR) begin
         rdata[CNT_W-1:0] = cnt;
      end else if (addr == CTRL_ADDR) begin
         rdata[CTRL_EN_BIT]   = te_q;
         rdata[CTRL_MODE_BIT] = mode_q;
         rdata[CTRL_IE_BIT]   = ie_q;
         rdata[SEL_W-1:0]     = sel_q;
      end
   end

   assign te   = te_q;
   assign ie   = ie_q;
   assign mode = mode_q;
   assign sel  = sel_q;
   assign tf   = tf_q;
endmodule

// File: rtl/cdt_down_counter.sv
module cdt_down_counter #(
   parameter int CNT_W = 8,
   parameter int N_SRC = 4,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] tick_en,
   input  logic [SEL_W-1:0] sel,
   input  logic             te,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             sel_tick,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [N_SRC-1:0] hit;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_q;

   // one-hot qualified tick select
   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign hit[i] = tick_en[i] && (sel == SEL_W'(i));
   end

   assign sel_tick = te && (|hit);
   assign expire   = sel_tick && !load && (cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         reload_q <= '0;
      end else if (load) begin
         cnt_q    <= load_val;
         reload_q <= load_val;
      end else if (sel_tick) begin
         if (cnt_q == '0) begin
            cnt_q <= reload_q;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/cdt_irq_out.sv
module cdt_irq_out
   import cdt_pkg::*;
#(
   parameter int PULSE_CAP = 16,
   parameter bit REG_OUT   = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      te,
   input  logic      ie,
   input  irq_mode_e mode,
   input  logic      tf,
   input  logic      expire,
   input  logic      sel_tick,
   input  logic      ext_irq,
   output logic      irq_n
);
   localparam int PW = $clog2(PULSE_CAP + 1);
   localparam logic [PW-1:0] CAP   = PW'(PULSE_CAP);
   localparam logic [PW-1:0] P_ONE = {{(PW-1){1'b0}}, 1'b1};

   logic          pulse_ok;
   logic [PW-1:0] pcnt_q;
   logic          tmr_irq;
   logic          irq_req;

   assign pulse_ok = te && ie && (mode == IRQ_PULSE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt_q <= '0;
      end else if (!pulse_ok) begin
         pcnt_q <= '0;
      end else if (expire) begin
         pcnt_q <= CAP;
      end else if (sel_tick) begin
         pcnt_q <= '0;
      end else if (pcnt_q != '0) begin
         pcnt_q <= pcnt_q - P_ONE;
      end
   end

   always_comb begin
      if (mode == IRQ_PULSE) begin
         tmr_irq = pulse_ok && (pcnt_q != '0);
      end else begin
         tmr_irq = ie && tf;
      end
   end

   assign irq_req = ext_irq || tmr_irq;

   if (REG_OUT) begin : g_reg_out
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b1;
         else        irq_q <= !irq_req;
      end
      assign irq_n = irq_q;
   end else begin : g_comb_out
      assign irq_n = !irq_req;
   end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
   import cdt_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int CNT_W     = 8,
   parameter int N_SRC     = 4,
   parameter int PULSE_CAP = 16,
   parameter bit REG_OUT   = 1'b0,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h0F,
   parameter logic [ADDR_W-1:0] VAL_ADDR  = 8'h10,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_SRC-1:0]  tick_en,
   input  logic              ext_irq,
   output logic              irq_n
);
   localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   if (CNT_W > DATA_W) begin : g_chk_cnt
      $error("cdt_timer: CNT_W must not exceed DATA_W");
   end
   if (DATA_W < 8) begin : g_chk_data
      $error("cdt_timer: control layout needs DATA_W >= 8");
   end
   if (N_SRC < 2 || N_SRC > 4) begin : g_chk_src
      $error("cdt_timer: rate select field holds 2 to 4 sources");
   end
   if (PULSE_CAP < 1) begin : g_chk_cap
      $error("cdt_timer: PULSE_CAP must be at least 1");
   end

   logic             te_w;
   logic             ie_w;
   irq_mode_e        mode_w;
   logic [SEL_W-1:0] sel_w;
   logic             tf_w;
   logic             val_wr_w;
   logic [CNT_W-1:0] cnt_w;
   logic             sel_tick_w;
   logic             expire_w;

   cdt_ctrl_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W),
      .FLAG_ADDR(FLAG_ADDR), .VAL_ADDR(VAL_ADDR), .CTRL_ADDR(CTRL_ADDR)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_we),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .expire(expire_w),
      .cnt   (cnt_w),
      .te    (te_w),
      .ie    (ie_w),
      .mode  (mode_w),
      .sel   (sel_w),
      .tf    (tf_w),
      .val_wr(val_wr_w),
      .rdata (bus_rdata)
   );

   cdt_down_counter #(
      .CNT_W(CNT_W), .N_SRC(N_SRC), .SEL_W(SEL_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .sel     (sel_w),
      .te      (te_w),
      .load    (val_wr_w),
      .load_val(bus_wdata[CNT_W-1:0]),
      .cnt     (cnt_w),
      .sel_tick(sel_tick_w),
      .expire  (expire_w)
   );

   cdt_irq_out #(
      .PULSE_CAP(PULSE_CAP), .REG_OUT(REG_OUT)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .te      (te_w),
      .ie      (ie_w),
      .mode    (mode_w),
      .tf      (tf_w),
      .expire  (expire_w),
      .sel_tick(sel_tick_w),
      .ext_irq (ext_irq),
      .irq_n   (irq_n)
   );
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8,
   parameter int N_SRC  = 4,
   parameter int SEL_W  = 2,
   parameter bit REG_OUT = 1'b0,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h0F,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [N_SRC-1:0]  tick_en,
   input logic              ext_irq,
   input logic              irq_n,
   input logic              te,
   input logic              ie,
   input logic              mode,
   input logic [SEL_W-1:0]  sel,
   input logic              tf,
   input logic              val_wr,
   input logic [CNT_W-1:0]  cnt
);
   logic clr_wr;
   logic ctl_wr;
   assign clr_wr = bus_we && (bus_addr == FLAG_ADDR) && !bus_wdata[3];
   assign ctl_wr = bus_we && (bus_addr == CTRL_ADDR);

   assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!te && !val_wr) |=> $stable(cnt));

   assert_expiry_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (te && tick_en[sel] && !val_wr && cnt == CNT_W'(1)) |=> tf);

   assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tf && !clr_wr) |=> tf);

   if (!REG_OUT) begin : g_comb_props
      assert_level_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!mode && ie && tf) |-> !irq_n);

      assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (mode && ie && te && tick_en[sel] && !val_wr && cnt == CNT_W'(1) && !ctl_wr)
         |=> !irq_n);

      assert_no_ie_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!ie && !ext_irq) |-> irq_n);

      assert_no_te_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (mode && !te && !ext_irq) |-> irq_n);

      assert_ext_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ext_irq |-> !irq_n);
   end

   assert_rsv_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == CTRL_ADDR) |-> (bus_rdata[4:2] == 3'b000));
endmodule

bind cdt_timer cdt_timer_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .N_SRC(N_SRC),
   .SEL_W(SEL_W), .REG_OUT(REG_OUT), .FLAG_ADDR(FLAG_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_cdt_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .tick_en  (tick_en),
   .ext_irq  (ext_irq),
   .irq_n    (irq_n),
   .te       (te_w),
   .ie       (ie_w),
   .mode     (mode_w),
   .sel      (sel_w),
   .tf       (tf_w),
   .val_wr   (val_wr_w),
   .cnt      (cnt_w)
);

// File: tb/test_cdt_timer.sv
`timescale 1ns/1ps
module test_cdt_timer;
   localparam int CAP = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       we = 1'b0;
   logic [7:0] addr = 8'h00;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [3:0] tick = 4'h0;
   logic       ext = 1'b0;
   logic       irq_n;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   cdt_timer i_cdt_timer (
      .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .tick_en(tick),
      .ext_irq(ext), .irq_n(irq_n)
   );

   // reference model built from the requirements
   logic [7:0] m_cnt, m_rel;
   logic       m_tf, m_te, m_ie, m_mode;
   logic [1:0] m_sel;
   int         m_pc;

   always @(posedge clk) begin
      logic vwr, fwr, cwr, st, ex;
      if (!rst_n) begin
         m_cnt <= 0; m_rel <= 0; m_tf <= 0; m_te <= 0;
         m_ie <= 0; m_mode <= 0; m_sel <= 0; m_pc <= 0;
      end else begin
         vwr = we && addr == 8'h10;
         fwr = we && addr == 8'h0F;
         cwr = we && addr == 8'h11;
         st  = m_te && tick[m_sel];
         ex  = st && !vwr && m_cnt == 8'd1;
         if (vwr) begin m_cnt <= wdata; m_rel <= wdata; end
         else if (st) m_cnt <= (m_cnt == 0) ? m_rel : m_cnt - 8'd1;
         if (ex) m_tf <= 1'b1;
         else if (fwr && !wdata[3]) m_tf <= 1'b0;
         if (cwr) begin
            m_te <= wdata[7]; m_mode <= wdata[6]; m_ie <= wdata[5]; m_sel <= wdata[1:0];
         end
         if (!(m_te && m_ie && m_mode)) m_pc <= 0;
         else if (ex) m_pc <= CAP;
         else if (st) m_pc <= 0;
         else if (m_pc != 0) m_pc <= m_pc - 1;
      end
   end

   function automatic logic [7:0] exp_rd(input logic [7:0] a);
      if (a == 8'h0F) return {4'h0, m_tf, 3'b000};
      if (a == 8'h10) return m_cnt;
      if (a == 8'h11) return {m_te, m_mode, m_ie, 3'b000, m_sel};
      return 8'h00;
   endfunction

   function automatic logic exp_irq_n();
      logic t;
      t = m_mode ? (m_te && m_ie && m_pc != 0) : (m_ie && m_tf);
      return !(ext || t);
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, expv);
      end
   endtask

   task automatic cycle(input logic w, input logic [7:0] a, input logic [7:0] d,
                        input logic [3:0] t, input logic e);
      we = w; addr = a; wdata = d; tick = t; ext = e;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      cycle(1'b1, a, d, 4'h0, 1'b0);
   endtask

   task automatic tk(input logic [3:0] t);
      cycle(1'b0, 8'h00, 8'h00, t, 1'b0);
   endtask

   task automatic peek(input logic [7:0] a, output logic [7:0] v);
      we = 1'b0; tick = 4'h0; addr = a;
      #0.5;
      v = rdata;
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      process::self().srandom(32'd1234);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      peek(8'h0F, v); chk("R1 flags", v, 8'h00);
      peek(8'h10, v); chk("R1 value", v, 8'h00);
      peek(8'h11, v); chk("R1 ctrl", v, 8'h00);
      chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
      // R2 load
      wr(8'h10, 8'd3);
      peek(8'h10, v); chk("R2 load", v, 8'd3);
      tk(4'h1);
      peek(8'h10, v); chk("R3 hold while disabled", v, 8'd3);
      wr(8'h11, 8'hA0);
      tk(4'h2);
      peek(8'h10, v); chk("R3 unselected tick", v, 8'd3);
      tk(4'h1); tk(4'h1);
      peek(8'h10, v); chk("R3 decrement", v, 8'd1);
      peek(8'h0F, v); chk("R4 no flag yet", v, 8'h00);
      tk(4'h1);
      peek(8'h0F, v); chk("R4 flag on expiry", v, 8'h08);
      chk("R6 level irq low", {7'b0, irq_n}, 8'h00);
      tk(4'h1);
      peek(8'h10, v); chk("R4 reload", v, 8'd3);
      wr(8'h0F, 8'hFF);
      peek(8'h0F, v); chk("R5 write one keeps", v, 8'h08);
      wr(8'h0F, 8'h00);
      peek(8'h0F, v); chk("R5 clear", v, 8'h00);
      chk("R6 level irq released", {7'b0, irq_n}, 8'h01);
      tk(4'h1); tk(4'h1);
      cycle(1'b1, 8'h0F, 8'h00, 4'h1, 1'b0);
      peek(8'h0F, v); chk("R5 expiry beats clear", v, 8'h08);
      wr(8'h0F, 8'h00);
      // R7 pulse mode, cap end
      wr(8'h11, 8'hE0);
      wr(8'h10, 8'd1);
      tk(4'h1);
      chk("R7 pulse starts", {7'b0, irq_n}, 8'h00);
      wr(8'h0F, 8'h00);
      chk("R7 flag clear keeps pulse", {7'b0, irq_n}, 8'h00);
      repeat (CAP - 2) tk(4'h0);
      chk("R7 pulse before cap", {7'b0, irq_n}, 8'h00);
      tk(4'h0);
      chk("R7 pulse capped", {7'b0, irq_n}, 8'h01);
      // R7 pulse ended by next tick
      tk(4'h1); tk(4'h1);
      chk("R7 second pulse", {7'b0, irq_n}, 8'h00);
      tk(4'h1);
      chk("R7 tick ends pulse", {7'b0, irq_n}, 8'h01);
      // R8 kill by interrupt enable
      tk(4'h1);
      chk("R8 pulse running", {7'b0, irq_n}, 8'h00);
      wr(8'h11, 8'hC0);
      chk("R8 ie off kills pulse", {7'b0, irq_n}, 8'h01);
      // R9 external source
      cycle(1'b0, 8'h00, 8'h00, 4'h0, 1'b1);
      chk("R9 ext forces low", {7'b0, irq_n}, 8'h00);
      ext = 1'b0;
      // R10 reserved bits
      wr(8'h11, 8'hFF);
      peek(8'h11, v); chk("R10 ctrl rsv", v, 8'hE3);
      peek(8'h20, v); chk("R10 unmapped", v, 8'h00);
      wr(8'h0F, 8'hF7);
      peek(8'h0F, v); chk("R10 flag rsv", v, 8'h00);
      // R4 zero reload never expires
      wr(8'h11, 8'h80);
      wr(8'h10, 8'h00);
      repeat (5) tk(4'h1);
      peek(8'h0F, v); chk("R4 zero no flag", v, 8'h00);
      peek(8'h10, v); chk("R4 zero stays", v, 8'h00);
      // random phase against the model
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] a, d;
         logic w;
         int r;
         r = $urandom % 4;
         a = (r == 0) ? 8'h0F : (r == 1) ? 8'h10 : (r == 2) ? 8'h11 : 8'($urandom);
         w = ($urandom % 10) == 0;
         d = 8'($urandom);
         if (a == 8'h10) d = 8'($urandom % 4);
         if (a == 8'h11 && ($urandom % 4) != 0) d[7] = 1'b1;
         cycle(w, a, d,
               {($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0},
               ($urandom % 32) == 0);
         chk("R6 R7 R8 R9 random irq_n", {7'b0, irq_n}, {7'b0, exp_irq_n()});
         chk("R2 R3 R4 R5 R10 random read", rdata, exp_rd(addr));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule